// File: doc/BRIEF.md
# Late-Write Pipelined Burst SRAM

This block is a synthesizable, cycle-accurate model of a synchronous pipelined burst SRAM. Read data comes back two clock edges after the read command. Write data is taken two clock edges after the write command. Because both operations have the same latency, a controller can issue reads and writes in any order and keep the data bus busy on every cycle.

Each word is 18 bits wide and is split into two 9-bit byte lanes. Each lane has its own active-low write enable. A burst begins with a load cycle, which captures the address, the chip selects, the operation type and the byte enables. Each following advance cycle steps a 2-bit counter over the two lowest address bits, in either interleaved or linear order. A clock-inhibit input freezes the whole pipeline for as long as it is held high.

The tristate data bus is split into a data input, a data output and an output-valid flag. The flag is high in the cycles where the bus would be driven.

Top module: `lwb_sram`

## Requirements
- R1: After a synchronous reset the pipeline holds no operation, and `rvalid_o` stays low until a read command has moved through both pipeline stages.
- R2: A load cycle (`adv_i`=0) with `rd_wrn_i`=1 and the device selected starts a read. `rdata_o` takes the word at the captured address, and `rvalid_o` is high, after the second un-inhibited edge following the command edge.
- R3: A load cycle with `rd_wrn_i`=0 starts a write. `wdata_i` is sampled at the second un-inhibited edge after the command. `be_n_i[0]`=0 stores bits 8:0 and `be_n_i[1]`=0 stores bits 17:9. A lane whose enable is high keeps its old contents. `rvalid_o` is low for a write.
- R4: A write with `be_n_i`=2'b11 stores nothing and leaves `rvalid_o` low.
- R5: A read always returns the newest data, including when it comes directly after a write to the same address, and including after a partial write merged into the old word. Reads and writes may follow each other with no idle cycle.
- R6: On an advance cycle (`adv_i`=1), `addr_i`, the three chip selects and `rd_wrn_i` are ignored. The burst keeps the operation type chosen by its load cycle. The byte enables are sampled again on each advance cycle.
- R7: With `order_i`=1, advance number k of a burst (counted modulo 4) accesses low address bits equal to the start bits XOR k.
- R8: With `order_i`=0, the low address bits equal the start bits plus k, modulo 4. Only bits 1:0 change during a burst, so the address returns to its start every fourth cycle.
- R9: A load cycle with `sel_a_n_i`=1, `sel_b_i`=0 or `sel_c_n_i`=1 deselects the device, and no operation enters the pipeline. Operations already in the pipeline still complete.
- R10: Advance cycles after a deselect, or after reset, keep the device deselected: nothing is read or written.
- R11: While `hold_i`=1, no state changes at that edge: no write happens and no counter moves. `rvalid_o` and `rdata_o` keep their values, so a read in progress stays on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| hold_i | input | 1 | Clock inhibit; freezes the block for that edge |
| sel_a_n_i | input | 1 | Active-low chip select, sampled on load cycles |
| sel_b_i | input | 1 | Active-high chip select, sampled on load cycles |
| sel_c_n_i | input | 1 | Active-low chip select, sampled on load cycles |
| adv_i | input | 1 | 1 = advance the burst, 0 = load a new command |
| rd_wrn_i | input | 1 | On load: 1 = read, 0 = write |
| be_n_i | input | 2 | Active-low byte-lane write enables |
| order_i | input | 1 | Burst order: 1 = interleaved (XOR), 0 = linear (add) |
| addr_i | input | AW | Word address, sampled on load cycles |
| wdata_i | input | 18 | Write data, sampled two edges after its command |
| rdata_o | output | 18 | Read data |
| rvalid_o | output | 1 | High when `rdata_o` carries read data (bus driven) |

## Verification
The bench builds the block with `AW`=5, a 32-word array, instead of the default of 6. With the smaller array, random traffic keeps hitting the same words. That brings read-after-write collisions, partial-lane merges and bursts that wrap inside their four-word group into reach within a few thousand cycles. The address width is still large enough that the upper bits must stay fixed while a burst steps only bits 1:0.

// File: rtl/lwb_pkg.sv
package lwb_pkg;

    // Byte-lane geometry of one array word.
    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    // Edges between a command and its data beat (read return or write sample).
    localparam int PIPE_STAGES = 2;

    // Width of the burst counter; it steps the low address bits only.
    localparam int BURST_W = 2;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } op_kind_e;

    // Low address bits for burst step 'step' from start 'start'.
    function automatic logic [BURST_W-1:0] burst_low(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] step,
        input logic               interleave
    );
        logic [BURST_W-1:0] res;
        if (interleave) begin
            res = start ^ step;
        end else begin
            res = start + step;
        end
        return res;
    endfunction

endpackage

// File: rtl/lwb_burst_ctl.sv
module lwb_burst_ctl
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 hold_i,
    input  logic                 sel_a_n_i,
    input  logic                 sel_b_i,
    input  logic                 sel_c_n_i,
    input  logic                 adv_i,
    input  logic                 rd_wrn_i,
    input  logic                 order_i,
    input  logic [AW-1:0]        addr_i,
    output op_kind_e             op_kind_o,
    output logic [AW-1:0]        op_addr_o
);

    localparam int HI_W = AW - BURST_W;

    op_kind_e           mode_q;
    logic [AW-1:0]      base_q;
    logic [BURST_W-1:0] cnt_q;

    logic               deselect;
    logic [BURST_W-1:0] step;
    logic [BURST_W-1:0] low_bits;

    // Operation entering the pipeline at this edge.
    always_comb begin
        deselect = sel_a_n_i | ~sel_b_i | sel_c_n_i;
        step     = cnt_q + BURST_W'(1);
        low_bits = burst_low(base_q[BURST_W-1:0], step, order_i);
        if (!adv_i) begin
            if (deselect) begin
                op_kind_o = OP_NONE;
            end else if (rd_wrn_i) begin
                op_kind_o = OP_READ;
            end else begin
                op_kind_o = OP_WRITE;
            end
            op_addr_o = addr_i;
        end else begin
            op_kind_o = mode_q;
            op_addr_o = {base_q[AW-1 -: HI_W], low_bits};
        end
    end

    // Burst state: kind chosen at load, start address, step count.
    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= OP_NONE;
            base_q <= '0;
            cnt_q  <= '0;
        end else if (!hold_i) begin
            if (!adv_i) begin
                mode_q <= op_kind_o;
                base_q <= addr_i;
                cnt_q  <= '0;
            end else begin
                cnt_q  <= step;
            end
        end
    end

    // R6: each un-held advance moves the counter by one (wrapping at four).
    p_count_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i) |=> (cnt_q == $past(cnt_q) + BURST_W'(1)));

    // R11: an inhibited edge leaves the burst state untouched.
    p_ctl_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ($stable(cnt_q) && $stable(base_q) && $stable(mode_q)));

endmodule

// File: rtl/lwb_pipe.sv
module lwb_pipe
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  op_kind_e          in_kind_i,
    input  logic [AW-1:0]     in_addr_i,
    input  logic [LANES-1:0]  in_be_n_i,
    output op_kind_e          head_kind_o,
    output op_kind_e          tail_kind_o,
    output logic [AW-1:0]     tail_addr_o,
    output logic [LANES-1:0]  tail_be_n_o
);

    localparam int LAST = PIPE_STAGES - 1;

    op_kind_e          kind_q [PIPE_STAGES];
    logic [AW-1:0]     addr_q [PIPE_STAGES];
    logic [LANES-1:0]  be_q   [PIPE_STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < PIPE_STAGES; s++) begin
                kind_q[s] <= OP_NONE;
                addr_q[s] <= '0;
                be_q[s]   <= '1;
            end
        end else if (!hold_i) begin
            kind_q[0] <= in_kind_i;
            addr_q[0] <= in_addr_i;
            be_q[0]   <= in_be_n_i;
            for (int s = 1; s < PIPE_STAGES; s++) begin
                kind_q[s] <= kind_q[s-1];
                addr_q[s] <= addr_q[s-1];
                be_q[s]   <= be_q[s-1];
            end
        end
    end

    assign head_kind_o = kind_q[0];
    assign tail_kind_o = kind_q[LAST];
    assign tail_addr_o = addr_q[LAST];
    assign tail_be_n_o = be_q[LAST];

    for (genvar s = 1; s < PIPE_STAGES; s++) begin : g_stage_chk
        // R2: a pending operation moves one stage per un-held edge and keeps its target.
        p_stage_shift_r2: assert property (@(posedge clk) disable iff (rst)
            (!hold_i && kind_q[s-1] != OP_NONE) |=>
                (kind_q[s] == $past(kind_q[s-1]) && addr_q[s] == $past(addr_q[s-1])));
    end

endmodule

// File: rtl/lwb_array.sv
module lwb_array
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  op_kind_e          kind_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    localparam int WORDS = 1 << AW;

    logic              commit;
    logic [WORD_W-1:0] rd_word;

    assign commit = !rst && !hold_i;

    // One storage bank per byte lane, each with its own write enable.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] bank [WORDS];

        always_ff @(posedge clk) begin
            if (commit && kind_i == OP_WRITE && !be_n_i[g]) begin
                bank[addr_i] <= wdata_i[g*LANE_W +: LANE_W];
            end
        end

        assign rd_word[g*LANE_W +: LANE_W] = bank[addr_i];
    end

    // Output register: a read in the last stage loads the newest stored word.
    always_ff @(posedge clk) begin
        if (rst) begin
            rvalid_o <= 1'b0;
            rdata_o  <= '0;
        end else if (!hold_i) begin
            rvalid_o <= (kind_i == OP_READ);
            if (kind_i == OP_READ) begin
                rdata_o <= rd_word;
            end
        end
    end

    // R1: the edge after reset leaves the output undriven.
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !rvalid_o);

    // R2: a read reaching the last stage drives the output.
    p_read_drives_r2: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && kind_i == OP_READ) |=> rvalid_o);

    // R3: writes, aborted writes and idle slots leave the output undriven.
    p_write_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && kind_i != OP_READ) |=> !rvalid_o);

endmodule

// File: rtl/lwb_sram.sv
module lwb_sram
    import lwb_pkg::*;
#(
    parameter int AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold_i,
    input  logic              sel_a_n_i,
    input  logic              sel_b_i,
    input  logic              sel_c_n_i,
    input  logic              adv_i,
    input  logic              rd_wrn_i,
    input  logic [LANES-1:0]  be_n_i,
    input  logic              order_i,
    input  logic [AW-1:0]     addr_i,
    input  logic [WORD_W-1:0] wdata_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              rvalid_o
);

    op_kind_e          new_kind;
    logic [AW-1:0]     new_addr;
    op_kind_e          head_kind;
    op_kind_e          tail_kind;
    logic [AW-1:0]     tail_addr;
    logic [LANES-1:0]  tail_be_n;

    lwb_burst_ctl #(.AW(AW)) u_ctl (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_i),
        .sel_a_n_i (sel_a_n_i),
        .sel_b_i   (sel_b_i),
        .sel_c_n_i (sel_c_n_i),
        .adv_i     (adv_i),
        .rd_wrn_i  (rd_wrn_i),
        .order_i   (order_i),
        .addr_i    (addr_i),
        .op_kind_o (new_kind),
        .op_addr_o (new_addr)
    );

    lwb_pipe #(.AW(AW)) u_pipe (
        .clk         (clk),
        .rst         (rst),
        .hold_i      (hold_i),
        .in_kind_i   (new_kind),
        .in_addr_i   (new_addr),
        .in_be_n_i   (be_n_i),
        .head_kind_o (head_kind),
        .tail_kind_o (tail_kind),
        .tail_addr_o (tail_addr),
        .tail_be_n_o (tail_be_n)
    );

    lwb_array #(.AW(AW)) u_array (
        .clk      (clk),
        .rst      (rst),
        .hold_i   (hold_i),
        .kind_i   (tail_kind),
        .addr_i   (tail_addr),
        .be_n_i   (tail_be_n),
        .wdata_i  (wdata_i),
        .rdata_o  (rdata_o),
        .rvalid_o (rvalid_o)
    );

    // R9: a deselecting load puts an empty slot into the pipeline.
    p_deselect_empty_r9: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && !adv_i && (sel_a_n_i || !sel_b_i || sel_c_n_i)) |=>
            (head_kind == OP_NONE));

    // R6 / R10: an advance repeats the kind of the previous slot (burst or deselect).
    p_advance_keeps_op_r6: assert property (@(posedge clk) disable iff (rst)
        (!hold_i && adv_i) |=> (head_kind == $past(head_kind)));

    // R11: an inhibited edge keeps the output exactly as it was.
    p_hold_freeze_r11: assert property (@(posedge clk) disable iff (rst)
        hold_i |=> ($stable(rvalid_o) && $stable(rdata_o)));

endmodule

// File: tb/lwb_sram_bench.sv
`timescale 1ns/1ps
module lwb_sram_bench;
    import lwb_pkg::*;

    localparam int AW     = 5;
    localparam int NWORDS = 1 << AW;

    logic              clk = 1'b0;
    logic              rst;
    logic              hold_i;
    logic              sel_a_n_i;
    logic              sel_b_i;
    logic              sel_c_n_i;
    logic              adv_i;
    logic              rd_wrn_i;
    logic [LANES-1:0]  be_n_i;
    logic              order_i;
    logic [AW-1:0]     addr_i;
    logic [WORD_W-1:0] wdata_i;
    logic [WORD_W-1:0] rdata_o;
    logic              rvalid_o;

    always #2 clk = ~clk;

    lwb_sram #(.AW(AW)) u_lwb_sram (
        .clk       (clk),
        .rst       (rst),
        .hold_i    (hold_i),
        .sel_a_n_i (sel_a_n_i),
        .sel_b_i   (sel_b_i),
        .sel_c_n_i (sel_c_n_i),
        .adv_i     (adv_i),
        .rd_wrn_i  (rd_wrn_i),
        .be_n_i    (be_n_i),
        .order_i   (order_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .rvalid_o  (rvalid_o)
    );

    // Reference model: queue of pending operations, word mirror, burst state.
    int                qk[$];
    int                qa[$];
    int                qb[$];
    logic [WORD_W-1:0] mirror [NWORDS];
    int                m_mode;
    int                m_base;
    int                m_cnt;
    logic              exp_v;
    logic [WORD_W-1:0] exp_d;

    int    n_checks = 0;
    int    n_errors = 0;
    string cur_req  = "R1";
    bit    g_ord    = 1'b1;
    bit    done     = 1'b0;

    task automatic check_out();
        n_checks++;
        if (rvalid_o !== exp_v) begin
            n_errors++;
            $display("FAIL %s: rvalid_o=%0b expected %0b at %0t", cur_req, rvalid_o, exp_v, $time);
        end else if (exp_v === 1'b1 && !$isunknown(exp_d) && rdata_o !== exp_d) begin
            n_errors++;
            $display("FAIL %s: rdata_o=%h expected %h at %0t", cur_req, rdata_o, exp_d, $time);
        end
    endtask

    task automatic model_edge(input bit adv, input bit desel, input bit rw,
                              input int ad, input int be, input logic [WORD_W-1:0] wd);
        int k, a, lo, fk, fa, fb;
        if (!adv) begin
            if (desel) k = 0;
            else if (rw) k = 1;
            else k = 2;
            a      = ad;
            m_mode = k;
            m_base = ad;
            m_cnt  = 0;
        end else begin
            k     = m_mode;
            m_cnt = (m_cnt + 1) % 4;
            if (g_ord) lo = (m_base % 4) ^ m_cnt;
            else lo = ((m_base % 4) + m_cnt) % 4;
            a = (m_base / 4) * 4 + lo;
        end
        qk.push_back(k);
        qa.push_back(a);
        qb.push_back(be);
        fk = qk.pop_front();
        fa = qa.pop_front();
        fb = qb.pop_front();
        if (fk == 2) begin
            for (int l = 0; l < LANES; l++) begin
                if (((fb >> l) & 1) == 0) mirror[fa][l*LANE_W +: LANE_W] = wd[l*LANE_W +: LANE_W];
            end
            exp_v = 1'b0;
        end else if (fk == 1) begin
            exp_v = 1'b1;
            exp_d = mirror[fa];
        end else begin
            exp_v = 1'b0;
        end
    endtask

    task automatic cycle(input bit h, input bit a_n, input bit b, input bit c_n,
                         input bit adv, input bit rw, input logic [1:0] be, input int ad);
        logic [WORD_W-1:0] wd;
        wd = WORD_W'($urandom);
        @(negedge clk);
        hold_i    = h;
        sel_a_n_i = a_n;
        sel_b_i   = b;
        sel_c_n_i = c_n;
        adv_i     = adv;
        rd_wrn_i  = rw;
        be_n_i    = be;
        order_i   = g_ord;
        addr_i    = AW'(ad);
        wdata_i   = wd;
        @(posedge clk);
        if (!h) model_edge(adv, a_n | !b | c_n, rw, ad, int'(be), wd);
        #1 check_out();
    endtask

    task automatic rd(input int ad);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 2'($urandom), ad);
    endtask

    task automatic wr(input int ad, input logic [1:0] be);
        cycle(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, be, ad);
    endtask

    // Advance with junk on the ignored pins.
    task automatic adv_c(input logic [1:0] be);
        cycle(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), 1'b1, 1'($urandom), be,
              int'($urandom % NWORDS));
    endtask

    task automatic dsel(input int which);
        cycle(1'b0, which == 0, which != 1, which == 2, 1'b0, 1'($urandom), 2'b00,
              int'($urandom % NWORDS));
    endtask

    task automatic hold_c();
        cycle(1'b1, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
              2'($urandom), int'($urandom % NWORDS));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        hold_i = 1'b0;
        adv_i = 1'b0;
        repeat (2) @(posedge clk);
        qk.delete(); qa.delete(); qb.delete();
        for (int s = 0; s < PIPE_STAGES; s++) begin
            qk.push_back(0); qa.push_back(0); qb.push_back(3);
        end
        m_mode = 0; m_base = 0; m_cnt = 0;
        exp_v = 1'b0;
        #1 check_out();
        @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        rst = 1'b1; hold_i = 1'b0; sel_a_n_i = 1'b1; sel_b_i = 1'b0; sel_c_n_i = 1'b1;
        adv_i = 1'b0; rd_wrn_i = 1'b1; be_n_i = '1; order_i = 1'b1; addr_i = '0; wdata_i = '0;
        exp_v = 1'b0; exp_d = '0;

        // R1: reset state, then deselects and advances keep the output quiet.
        cur_req = "R1";
        do_reset();
        dsel(0); dsel(1); dsel(2);

        // R10: advances straight after reset stay deselected.
        cur_req = "R10";
        do_reset();
        repeat (5) adv_c(2'b00);

        // R3: fill the whole array with back-to-back full writes.
        cur_req = "R3";
        for (int a = 0; a < NWORDS; a++) wr(a, 2'b00);
        dsel(0); dsel(0);

        // R2: back-to-back reads.
        cur_req = "R2";
        for (int a = 0; a < 8; a++) rd(a * 3 % NWORDS);
        dsel(1); dsel(1);

        // R3: lane-selective writes then read back.
        cur_req = "R3";
        wr(4, 2'b10); wr(5, 2'b01); rd(4); rd(5); dsel(0); dsel(0);

        // R4: aborted write leaves the word unchanged.
        cur_req = "R4";
        wr(6, 2'b11); rd(6); dsel(2); dsel(2);

        // R5: write/read turnaround on the same word with no idle cycle.
        cur_req = "R5";
        wr(7, 2'b00); rd(7); rd(7); wr(7, 2'b01); rd(7); wr(7, 2'b10); rd(7);
        rd(8); wr(8, 2'b00); rd(8); dsel(0); dsel(0);

        // R6: bursts keep their kind; ignored pins carry junk.
        cur_req = "R6";
        g_ord = 1'b1;
        rd(9); repeat (4) adv_c(2'b00);
        wr(9, 2'b00); adv_c(2'b10); adv_c(2'b01); adv_c(2'b11); adv_c(2'b00);
        rd(9); repeat (3) adv_c(2'b00);
        dsel(0); dsel(0);

        // R7: interleaved order from odd and even starts.
        cur_req = "R7";
        g_ord = 1'b1;
        wr(18, 2'b00); repeat (3) adv_c(2'b00);
        rd(18); repeat (3) adv_c(2'b00);
        rd(23); repeat (4) adv_c(2'b00);
        dsel(0); dsel(0);

        // R8: linear order, wrap after four beats.
        cur_req = "R8";
        g_ord = 1'b0;
        wr(13, 2'b00); repeat (3) adv_c(2'b00);
        rd(13); repeat (5) adv_c(2'b00);
        rd(31); repeat (3) adv_c(2'b00);
        dsel(0); dsel(0);

        // R9: deselect right behind pending operations.
        cur_req = "R9";
        wr(2, 2'b00); dsel(0); rd(2); rd(3); dsel(1); dsel(2); dsel(2);

        // R10: advances after a deselect keep it deselected.
        cur_req = "R10";
        rd(1); dsel(0); repeat (4) adv_c(2'b00); dsel(0); dsel(0);

        // R11: inhibited edges inside read and write traffic.
        cur_req = "R11";
        g_ord = 1'b1;
        rd(10); adv_c(2'b00); hold_c(); hold_c(); adv_c(2'b00); hold_c(); adv_c(2'b00);
        wr(11, 2'b00); dsel(0); hold_c(); hold_c(); dsel(0); rd(11); hold_c(); dsel(0); dsel(0);

        // R5: random mixed traffic against the model.
        cur_req = "R5";
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 12);
            if (i % 97 == 0) g_ord = ~g_ord;
            if (r < 3) rd(int'($urandom % NWORDS));
            else if (r < 6) wr(int'($urandom % NWORDS), 2'($urandom));
            else if (r < 9) adv_c(2'($urandom));
            else if (r < 10) hold_c();
            else dsel(int'($urandom % 3));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        done = 1'b1;
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule